// File: doc/BRIEF.md
# Modulo Up/Down Counter with Layered Controls

This block is a parameterised binary counter whose cycle length is set by a modulus parameter. It steps up or down, taking its direction either from a runtime pin or from a fixed configuration. Its value can be forced in two ways. Asynchronous clear, set and load controls act at once. Clocked clear, set and load controls act on the next rising edge. Both groups follow a fixed priority. A clock enable gates all clocked activity. A count enable and a carry-in each gate only the count step.

Besides the count, the block drives a carry-out that flags a pending wrap and sixteen one-hot decode flags for the counts zero to fifteen. A priority arbiter reduces the control pins to a single action each cycle. The named actions are:

- ACT_ACLR, ACT_ASET and ACT_ALOAD for the asynchronous controls.
- ACT_HOLD when the clock enable is low or no step is allowed.
- ACT_SCLR, ACT_SSET and ACT_SLOAD for the clocked controls.
- ACT_STEP_UP and ACT_STEP_DN for counting.

The register moves from its current value to the value that the action names. The asynchronous actions take effect without a clock edge. Every other action takes effect at the rising edge.

Top module: `modulo_updown_counter`

## Requirements
- R1: While `async_clr` is high, `count` is zero at once, whatever any other input does.
- R2: While `async_set` is high and `async_clr` is low, `count` equals the parameter ASET_VAL, which defaults to all ones. This also holds when `async_ld` is high.
- R3: While `async_ld` is high and the other two asynchronous controls are low, `count` follows `load_val`. When no asynchronous control is active and `clk_en` is high, a rising edge with `sync_ld` high (and `sync_clr`, `sync_set` low) loads `load_val`.
- R4: With no asynchronous control active and `clk_en` low, `count` keeps its value across a rising edge, whatever the clocked controls do.
- R5: At a rising edge with `clk_en` high, `sync_clr` takes precedence, then `sync_set`, then `sync_ld`, then counting. `sync_clr` gives zero.
- R6: `sync_set` loads the parameter SSET_VAL, which defaults to all ones and is independent of ASET_VAL.
- R7: The count steps only when `cnt_en` and `carry_in` are both high. Either one low blocks the step but leaves clocked clear, set and load working.
- R8: With DIR_SEL = 0, `dir_up` high counts up and low counts down. DIR_SEL = 1 always counts up and DIR_SEL = 2 always counts down, ignoring `dir_up`.
- R9: The top value TOP is MODULUS-1, or all ones when MODULUS is 0. Counting up from TOP gives zero, and counting down from zero gives TOP.
- R10: `carry_out` is high exactly when `carry_in` is high and `count` sits at the wrap point of the active direction: TOP when counting up, zero when counting down.
- R11: `eq_flag[k]` is high exactly when `count` equals k, for k from 0 to 15. All flags are low for counts of 16 or more, and they change in the same cycle as `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clk_en | input | 1 | Gates all clocked activity |
| cnt_en | input | 1 | Gates the count step only |
| carry_in | input | 1 | Carry into the low bit; gates the count step |
| dir_up | input | 1 | 1 = up, 0 = down (runtime direction mode only) |
| async_clr | input | 1 | Asynchronous clear, highest priority |
| async_set | input | 1 | Asynchronous set to ASET_VAL |
| async_ld | input | 1 | Asynchronous load from load_val |
| sync_clr | input | 1 | Clocked clear |
| sync_set | input | 1 | Clocked set to SSET_VAL |
| sync_ld | input | 1 | Clocked load from load_val |
| load_val | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Wrap pending in the active direction |
| eq_flag | output | 16 | One-hot decode of counts 0 to 15 |

## Verification
Results from the asynchronous controls, `carry_out` and `eq_flag` appear in the same cycle as the inputs that cause them. Results from the clocked controls and from counting appear after exactly one rising edge. The bench drives each vector on a falling edge and computes the value expected after the next rising edge. It queues that value and compares it 2 ns after that edge, so both kinds of result are seen in a settled state with the same inputs still applied. Two instances are checked side by side: one with a runtime direction and modulus 21, and one with a fixed down direction and a full binary cycle.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

    // Direction configuration values
    localparam int DIR_RUNTIME  = 0;
    localparam int DIR_FIXED_UP = 1;
    localparam int DIR_FIXED_DN = 2;

    // Number of decoded low counts
    localparam int DECODE_N = 16;

    // One action chosen per cycle by the priority arbiter
    typedef enum logic [3:0] {
        ACT_ACLR,
        ACT_ASET,
        ACT_ALOAD,
        ACT_HOLD,
        ACT_SCLR,
        ACT_SSET,
        ACT_SLOAD,
        ACT_STEP_UP,
        ACT_STEP_DN
    } cnt_act_e;

endpackage

// File: rtl/modcnt_arbiter.sv
module modcnt_arbiter
    import modcnt_pkg::*;
(
    input  logic     async_clr,
    input  logic     async_set,
    input  logic     async_ld,
    input  logic     clk_en,
    input  logic     sync_clr,
    input  logic     sync_set,
    input  logic     sync_ld,
    input  logic     cnt_en,
    input  logic     carry_in,
    input  logic     up_eff,
    output cnt_act_e act
);

    // Layered priority: asynchronous group first, then the enable, then
    // the clocked group, then the count step.
    always_comb begin
        if (async_clr)
            act = ACT_ACLR;
        else if (async_set)
            act = ACT_ASET;
        else if (async_ld)
            act = ACT_ALOAD;
        else if (!clk_en)
            act = ACT_HOLD;
        else if (sync_clr)
            act = ACT_SCLR;
        else if (sync_set)
            act = ACT_SSET;
        else if (sync_ld)
            act = ACT_SLOAD;
        else if (cnt_en && carry_in)
            act = up_eff ? ACT_STEP_UP : ACT_STEP_DN;
        else
            act = ACT_HOLD;
    end

endmodule

// File: rtl/modcnt_step.sv
module modcnt_step #(
    parameter int              WIDTH   = 8,
    parameter logic [WIDTH-1:0] TOP_VAL = '1
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] inc_val,
    output logic [WIDTH-1:0] dec_val
);

    // Wrap-aware neighbours of the current count
    assign inc_val = (cur == TOP_VAL) ? '0 : cur + 1'b1;
    assign dec_val = (cur == '0) ? TOP_VAL : cur - 1'b1;

endmodule

// File: rtl/modcnt_decode.sv
module modcnt_decode #(
    parameter int WIDTH = 8,
    parameter int FLAGS = 16
) (
    input  logic [WIDTH-1:0] value,
    output logic [FLAGS-1:0] hit
);

    localparam int CW = (WIDTH > 6) ? WIDTH : 6;

    logic [CW-1:0] value_ext;
    assign value_ext = CW'(value);

    for (genvar k = 0; k < FLAGS; k++) begin : g_flag
        assign hit[k] = (value_ext == CW'(k));
    end

endmodule

// File: rtl/modulo_updown_counter.sv
module modulo_updown_counter
    import modcnt_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter int               MODULUS  = 0,
    parameter int               DIR_SEL  = DIR_RUNTIME,
    parameter logic [WIDTH-1:0] ASET_VAL = '1,
    parameter logic [WIDTH-1:0] SSET_VAL = '1
) (
    input  logic             clk,
    input  logic             clk_en,
    input  logic             cnt_en,
    input  logic             carry_in,
    input  logic             dir_up,
    input  logic             async_clr,
    input  logic             async_set,
    input  logic             async_ld,
    input  logic             sync_clr,
    input  logic             sync_set,
    input  logic             sync_ld,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             carry_out,
    output logic [15:0]      eq_flag
);

    localparam logic [WIDTH-1:0] TOP_VAL =
        (MODULUS == 0) ? {WIDTH{1'b1}} : WIDTH'(MODULUS - 1);

    cnt_act_e         act;
    logic             up_eff;
    logic             async_hit;
    logic [WIDTH-1:0] async_val;
    logic [WIDTH-1:0] cnt_r;
    logic [WIDTH-1:0] inc_val;
    logic [WIDTH-1:0] dec_val;

    // Effective direction: fixed configurations ignore the pin
    assign up_eff    = (DIR_SEL == DIR_FIXED_UP) |
                       ((DIR_SEL == DIR_RUNTIME) & dir_up);
    assign async_hit = async_clr | async_set | async_ld;

    modcnt_arbiter u_arb (
        .async_clr (async_clr),
        .async_set (async_set),
        .async_ld  (async_ld),
        .clk_en    (clk_en),
        .sync_clr  (sync_clr),
        .sync_set  (sync_set),
        .sync_ld   (sync_ld),
        .cnt_en    (cnt_en),
        .carry_in  (carry_in),
        .up_eff    (up_eff),
        .act       (act)
    );

    modcnt_step #(
        .WIDTH   (WIDTH),
        .TOP_VAL (TOP_VAL)
    ) u_step (
        .cur     (cnt_r),
        .inc_val (inc_val),
        .dec_val (dec_val)
    );

    // Value forced by the asynchronous group
    always_comb begin
        unique case (act)
            ACT_ACLR: async_val = '0;
            ACT_ASET: async_val = ASET_VAL;
            default:  async_val = load_val;
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge async_hit) begin
        if (async_hit) begin
            cnt_r <= async_val;
        end else begin
            unique case (act)
                ACT_SCLR:    cnt_r <= '0;
                ACT_SSET:    cnt_r <= SSET_VAL;
                ACT_SLOAD:   cnt_r <= load_val;
                ACT_STEP_UP: cnt_r <= inc_val;
                ACT_STEP_DN: cnt_r <= dec_val;
                default:     cnt_r <= cnt_r;
            endcase
        end
    end

    // Outputs: async controls are transparent while held
    always_comb begin
        count     = async_hit ? async_val : cnt_r;
        carry_out = carry_in & (up_eff ? (count == TOP_VAL) : (count == '0));
    end

    modcnt_decode #(
        .WIDTH (WIDTH),
        .FLAGS (DECODE_N)
    ) u_dec (
        .value (count),
        .hit   (eq_flag)
    );

endmodule

// File: rtl/modcnt_checker.sv
module modcnt_checker
    import modcnt_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter int               MODULUS  = 0,
    parameter int               DIR_SEL  = DIR_RUNTIME,
    parameter logic [WIDTH-1:0] ASET_VAL = '1,
    parameter logic [WIDTH-1:0] SSET_VAL = '1
) (
    input logic             clk,
    input logic             clk_en,
    input logic             cnt_en,
    input logic             carry_in,
    input logic             dir_up,
    input logic             async_clr,
    input logic             async_set,
    input logic             async_ld,
    input logic             sync_clr,
    input logic             sync_set,
    input logic             sync_ld,
    input logic [WIDTH-1:0] load_val,
    input logic [WIDTH-1:0] count,
    input logic             carry_out,
    input logic [15:0]      eq_flag
);

    localparam logic [WIDTH-1:0] TOP_C =
        (MODULUS == 0) ? {WIDTH{1'b1}} : WIDTH'(MODULUS - 1);

    logic any_async;
    logic up_c;
    logic plain_step;
    assign any_async  = async_clr | async_set | async_ld;
    assign up_c       = (DIR_SEL == DIR_FIXED_UP) |
                        ((DIR_SEL == DIR_RUNTIME) & dir_up);
    assign plain_step = clk_en & ~sync_clr & ~sync_set & ~sync_ld &
                        cnt_en & carry_in;

    // R1
    aclr_zero_chk: assert property (@(posedge clk)
        async_clr |-> (count == '0));

    // R2
    aset_const_chk: assert property (@(posedge clk)
        (async_set && !async_clr) |-> (count == ASET_VAL));

    // R4
    gated_hold_chk: assert property (@(posedge clk) disable iff (any_async)
        !clk_en |=> (count == $past(count)));

    // R5
    sclr_first_chk: assert property (@(posedge clk) disable iff (any_async)
        (clk_en && sync_clr) |=> (count == '0));

    // R6
    sset_const_chk: assert property (@(posedge clk) disable iff (any_async)
        (clk_en && !sync_clr && sync_set) |=> (count == SSET_VAL));

    // R3
    sload_data_chk: assert property (@(posedge clk) disable iff (any_async)
        (clk_en && !sync_clr && !sync_set && sync_ld) |=> (count == $past(load_val)));

    // R9
    wrap_up_chk: assert property (@(posedge clk) disable iff (any_async)
        (plain_step && up_c && count == TOP_C) |=> (count == '0));

    // R9
    wrap_down_chk: assert property (@(posedge clk) disable iff (any_async)
        (plain_step && !up_c && count == '0) |=> (count == TOP_C));

    // R10
    carry_point_chk: assert property (@(posedge clk) disable iff (any_async)
        carry_out |-> (carry_in && (count == TOP_C || count == '0)));

    // R11
    decode_onehot_chk: assert property (@(posedge clk)
        $onehot0(eq_flag) && ((eq_flag != '0) == (count < WIDTH'(16) || WIDTH < 5)));

endmodule

bind modulo_updown_counter modcnt_checker #(
    .WIDTH    (WIDTH),
    .MODULUS  (MODULUS),
    .DIR_SEL  (DIR_SEL),
    .ASET_VAL (ASET_VAL),
    .SSET_VAL (SSET_VAL)
) u_modcnt_chk (
    .clk       (clk),
    .clk_en    (clk_en),
    .cnt_en    (cnt_en),
    .carry_in  (carry_in),
    .dir_up    (dir_up),
    .async_clr (async_clr),
    .async_set (async_set),
    .async_ld  (async_ld),
    .sync_clr  (sync_clr),
    .sync_set  (sync_set),
    .sync_ld   (sync_ld),
    .load_val  (load_val),
    .count     (count),
    .carry_out (carry_out),
    .eq_flag   (eq_flag)
);

// File: tb/modulo_updown_counter_bench.sv
module modulo_updown_counter_bench;

    // Instance A: 5 bits, modulus 21, runtime direction
    localparam int A_TOP  = 20;
    localparam int A_ASET = 7;
    localparam int A_SSET = 19;
    // Instance B: 4 bits, full cycle, fixed down, default set constants
    localparam int B_TOP  = 15;
    localparam int B_ASET = 15;
    localparam int B_SSET = 15;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic clk_en = 1'b0, cnt_en = 1'b0, carry_in = 1'b1, dir_up = 1'b1;
    logic async_clr = 1'b1, async_set = 1'b0, async_ld = 1'b0;
    logic sync_clr = 1'b0, sync_set = 1'b0, sync_ld = 1'b0;
    logic [4:0] data = '0;

    logic [4:0]  a_count;
    logic        a_cout;
    logic [15:0] a_eq;
    logic [3:0]  b_count;
    logic        b_cout;
    logic [15:0] b_eq;

    modulo_updown_counter #(
        .WIDTH(5), .MODULUS(21), .DIR_SEL(0),
        .ASET_VAL(5'd7), .SSET_VAL(5'd19)
    ) u_modulo_updown_counter (
        .clk(clk), .clk_en(clk_en), .cnt_en(cnt_en), .carry_in(carry_in),
        .dir_up(dir_up), .async_clr(async_clr), .async_set(async_set),
        .async_ld(async_ld), .sync_clr(sync_clr), .sync_set(sync_set),
        .sync_ld(sync_ld), .load_val(data), .count(a_count),
        .carry_out(a_cout), .eq_flag(a_eq)
    );

    modulo_updown_counter #(
        .WIDTH(4), .MODULUS(0), .DIR_SEL(2)
    ) u_modulo_updown_counter_dn (
        .clk(clk), .clk_en(clk_en), .cnt_en(cnt_en), .carry_in(carry_in),
        .dir_up(dir_up), .async_clr(async_clr), .async_set(async_set),
        .async_ld(async_ld), .sync_clr(sync_clr), .sync_set(sync_set),
        .sync_ld(sync_ld), .load_val(data[3:0]), .count(b_count),
        .carry_out(b_cout), .eq_flag(b_eq)
    );

    typedef struct {
        int    aq;
        int    aeq;
        bit    aco;
        string atag;
        int    bq;
        int    beq;
        bit    bco;
        string btag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   ma     = 0;
    int   mb     = 0;
    bit   done   = 1'b0;

    function automatic int step_model(input int cur, input int top, input int sset,
                                      input int d, input bit up);
        if (!clk_en)              return cur;
        if (sync_clr)             return 0;
        if (sync_set)             return sset;
        if (sync_ld)              return d;
        if (!(cnt_en && carry_in)) return cur;
        if (up)                   return (cur == top) ? 0 : cur + 1;
        return (cur == 0) ? top : cur - 1;
    endfunction

    function automatic string tag_of(input int cur, input int top, input bit up);
        if (async_clr)            return "R1";
        if (async_set)            return "R2";
        if (async_ld)             return "R3";
        if (!clk_en)              return "R4";
        if (sync_clr)             return "R5";
        if (sync_set)             return "R6";
        if (sync_ld)              return "R3";
        if (!(cnt_en && carry_in)) return "R7";
        if ((up && cur == top) || (!up && cur == 0)) return "R9";
        return "R8";
    endfunction

    function automatic int dec_model(input int v);
        return (v < 16) ? (1 << v) : 0;
    endfunction

    // Driver: apply one vector on the falling edge, push what is due after
    // the next rising edge
    task automatic drive(input bit ac, input bit as_, input bit al, input bit ce,
                         input bit sc, input bit ss, input bit sl, input bit en,
                         input bit ci, input bit up, input int d);
        exp_t e;
        int   da;
        int   db;
        @(negedge clk);
        async_clr = ac; async_set = as_; async_ld = al; clk_en = ce;
        sync_clr = sc; sync_set = ss; sync_ld = sl; cnt_en = en;
        carry_in = ci; dir_up = up; data = 5'(d);
        da = d & 31;
        db = d & 15;
        e.atag = tag_of(ma, A_TOP, up);
        e.btag = tag_of(mb, B_TOP, 1'b0);
        if (ac || as_ || al) begin
            ma = ac ? 0 : (as_ ? A_ASET : da);
            mb = ac ? 0 : (as_ ? B_ASET : db);
        end else begin
            ma = step_model(ma, A_TOP, A_SSET, da, up);
            mb = step_model(mb, B_TOP, B_SSET, db, 1'b0);
        end
        e.aq  = ma;
        e.aeq = dec_model(ma);
        e.aco = ci && (up ? (ma == A_TOP) : (ma == 0));
        e.bq  = mb;
        e.beq = dec_model(mb);
        e.bco = ci && (mb == 0);
        exp_q.push_back(e);
    endtask

    task automatic cmp(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
        end
    endtask

    // Monitor: compare 2 ns after every rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.atag, "A count", int'(a_count), e.aq);
                cmp("R11", "A eq_flag", int'(a_eq), e.aeq);
                cmp("R10", "A carry_out", int'(a_cout), int'(e.aco));
                cmp(e.btag, "B count", int'(b_count), e.bq);
                cmp("R11", "B eq_flag", int'(b_eq), e.beq);
                cmp("R10", "B carry_out", int'(b_cout), int'(e.bco));
            end
        end
    end

    function automatic bit pct(input int p);
        return $urandom_range(0, 99) < p;
    endfunction

    initial begin
        // R1: reset state through async clear
        drive(1,0,0, 1,0,0,0, 1,1,1, 3);
        drive(1,1,1, 1,1,1,1, 1,1,1, 9);
        // R8, R9: count up through the wrap of A; B counts down regardless
        for (int i = 0; i < 25; i++) drive(0,0,0, 1,0,0,0, 1,1,1, 0);
        // R8, R9: count down through zero
        for (int i = 0; i < 25; i++) drive(0,0,0, 1,0,0,0, 1,1,0, 0);
        // R7: count enable low and carry-in low block only counting
        drive(0,0,0, 1,0,0,0, 0,1,1, 0);
        drive(0,0,0, 1,0,0,0, 1,0,1, 0);
        drive(0,0,0, 1,0,0,1, 0,0,1, 12);
        drive(0,0,0, 1,1,0,0, 0,1,1, 0);
        drive(0,0,0, 1,0,1,0, 1,0,0, 0);
        // R5: set beats load, clear beats both
        drive(0,0,0, 1,0,1,1, 1,1,1, 4);
        drive(0,0,0, 1,1,1,1, 1,1,1, 4);
        // R4: gated enable ignores clocked controls
        drive(0,0,0, 1,0,0,1, 1,1,1, 13);
        drive(0,0,0, 0,1,1,1, 1,1,1, 2);
        drive(0,0,0, 0,0,0,0, 1,1,1, 2);
        // R2, R3: asynchronous set over load, load follows data
        drive(0,1,1, 1,1,0,0, 1,1,1, 17);
        drive(0,0,1, 1,1,1,0, 1,1,1, 17);
        drive(0,0,1, 0,0,0,0, 1,1,1, 5);
        drive(0,0,0, 1,0,0,0, 1,1,0, 5);
        // Random mixtures of every control
        for (int i = 0; i < 4000; i++) begin
            drive(pct(3), pct(3), pct(4), pct(85), pct(5), pct(5), pct(8),
                  pct(80), pct(85), (i / 40) % 2 == 0, $urandom_range(0, 20));
        end
        drive(0,0,0, 0,0,0,0, 0,1,1, 0);
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL R1 watchdog: actual hung expected finished");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule